// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing protocol engine of a two-wire serial memory. It runs in the system clock domain and oversamples the serial clock and data lines. It finds START and STOP conditions and shifts bytes in and out. It matches the device address byte against a fixed type code and three strap inputs. It then steps through writes and reads. The SDA pin is never driven high. The engine produces only a drive-low enable, and an external open-drain pad turns that enable into the bus level.

Behind the engine sits a companion block that holds the word-address counter, the write buffer and the storage. The engine gives that block single-cycle strobes: high address byte, low address byte, write data byte, read fetch, and write commit on STOP. It returns a busy flag while its internal write cycle runs. While busy is set the engine declines its device address, so a host can poll with the address byte until it gets an acknowledge.

Top module: `twm_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START and a rising SDA while SCL is high is a STOP. A START at any point abandons the current transfer, releases SDA and restarts device-byte reception. A STOP returns the engine to idle.
- R2: The first byte after a START is accepted only if bits 7:4 equal 1010, bits 3:1 equal `strap_i[2:0]` and busy is low. Bit 0 set to 1 means read and 0 means write. On a mismatch nothing is acknowledged and the bus is ignored until the next START.
- R3: Each accepted byte the engine receives is acknowledged by holding SDA low for the whole ninth SCL clock.
- R4: `sda_drive_o` changes only while the synchronized SCL is low. Input bits are taken on the SCL rising edge and output bits are changed after the SCL falling edge.
- R5: In a write, the two bytes after the device byte are the high and then the low word-address byte. Each is announced by a one-cycle strobe with the byte on `byte_o`. Every following byte gives one `wr_stb_o` pulse carrying that byte.
- R6: `commit_o` pulses once when a STOP ends a write that carried at least one data byte. A write holding only the address bytes, or one abandoned by a START, gives no commit.
- R7: In a read, `rd_req_o` pulses once the read device byte is accepted, and again after each byte the master acknowledges. The fetched byte is sent MSB first, a 0 bit as SDA held low.
- R8: When the master does not acknowledge a read byte, the engine leaves SDA released and waits for a START or a STOP.
- R9: While `busy_i` is high at the end of a device byte, that byte gets no acknowledge. The same byte is acknowledged once busy is low.
- R10: A START, nine clocks with SDA released, a START and a STOP leave the engine idle. A following transaction then works normally.
- R11: During and after reset, SDA is released and every strobe is low.
- R12: At most one of the strobes toward the companion block is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| strap_i | input | 3 | Device address straps |
| busy_i | input | 1 | Internal write cycle running in the companion block |
| rd_byte_i | input | 8 | Byte fetched by the companion block, valid the cycle after `rd_req_o` |
| sda_drive_o | output | 1 | Pull SDA low when high |
| byte_o | output | 8 | Received byte accompanying the address and write strobes |
| addr_hi_stb_o | output | 1 | High word-address byte received |
| addr_lo_stb_o | output | 1 | Low word-address byte received |
| wr_stb_o | output | 1 | Write data byte received |
| rd_req_o | output | 1 | Fetch next read byte and advance the address |
| commit_o | output | 1 | STOP closed a write carrying data |

## Verification
The busy flag and the end of the device byte can fall in the same cycle. The engine judges busy only at the rising edge that completes the eighth address bit. The bench raises `busy_i` a few cycles before that edge and expects no acknowledge. It then lowers busy and repeats the byte, expecting an acknowledge. A second coincidence is a repeated START that arrives right after a data strobe. The bench checks that this write strobe still happens and that no commit follows.

// File: rtl/twm_pkg.sv
package twm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_READ,
    ST_HOLD
  } twm_state_e;
endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '1;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/twm_line_events.sv
module twm_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twm_xfer.sv
module twm_xfer
  import twm_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter int          STRAP_W   = 3,
  parameter logic [3:0]  TYPE_CODE = 4'b1010
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_ev,
  input  logic               stop_ev,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic [BYTE_W-1:0]  rd_byte_i,
  output logic               sda_drive_o,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               addr_hi_stb_o,
  output logic               addr_lo_stb_o,
  output logic               wr_stb_o,
  output logic               rd_req_o,
  output logic               commit_o
);
  localparam int              CNT_W  = $clog2(BYTE_W + 2);
  localparam int              TYPE_W = BYTE_W - 1 - STRAP_W;
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] C_DONE = CNT_W'(BYTE_W + 1);

  twm_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-1:0] shreg;
  logic             do_ack, ack_slot, is_rd, wrote;
  logic [BYTE_W-1:0] incoming;
  logic             dev_match;

  assign incoming  = {shreg[BYTE_W-2:0], sda_s};
  assign dev_match = (incoming[BYTE_W-1 -: TYPE_W] == TYPE_CODE[TYPE_W-1:0]) &&
                     (incoming[STRAP_W:1] == strap_i) && !busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      cnt           <= '0;
      shreg         <= '0;
      do_ack        <= 1'b0;
      ack_slot      <= 1'b0;
      is_rd         <= 1'b0;
      wrote         <= 1'b0;
      sda_drive_o   <= 1'b0;
      byte_o        <= '0;
      addr_hi_stb_o <= 1'b0;
      addr_lo_stb_o <= 1'b0;
      wr_stb_o      <= 1'b0;
      rd_req_o      <= 1'b0;
      commit_o      <= 1'b0;
    end else begin
      addr_hi_stb_o <= 1'b0;
      addr_lo_stb_o <= 1'b0;
      wr_stb_o      <= 1'b0;
      rd_req_o      <= 1'b0;
      commit_o      <= 1'b0;
      if (start_ev) begin
        st          <= ST_DEV;
        cnt         <= '0;
        do_ack      <= 1'b0;
        ack_slot    <= 1'b0;
        wrote       <= 1'b0;
        sda_drive_o <= 1'b0;
      end else if (stop_ev) begin
        st          <= ST_IDLE;
        do_ack      <= 1'b0;
        ack_slot    <= 1'b0;
        sda_drive_o <= 1'b0;
        commit_o    <= wrote;
        wrote       <= 1'b0;
      end else begin
        case (st)
          ST_IDLE, ST_HOLD: sda_drive_o <= 1'b0;
          ST_READ: begin
            if (scl_rise) begin
              if (cnt < C_FULL) cnt <= cnt + 1'b1;
              else if (cnt == C_FULL) begin
                cnt <= C_DONE;
                if (!sda_s) rd_req_o <= 1'b1;
                else st <= ST_HOLD;
              end
            end else if (scl_fall) begin
              if (cnt < C_FULL) begin
                sda_drive_o <= ~shreg[BYTE_W-2];
                shreg       <= {shreg[BYTE_W-2:0], 1'b0};
              end else if (cnt == C_FULL) begin
                sda_drive_o <= 1'b0;
              end else begin
                shreg       <= rd_byte_i;
                sda_drive_o <= ~rd_byte_i[BYTE_W-1];
                cnt         <= '0;
              end
            end
          end
          default: begin
            if (scl_rise && !ack_slot && cnt < C_FULL) begin
              shreg <= incoming;
              cnt   <= cnt + 1'b1;
              if (cnt == C_LAST) begin
                case (st)
                  ST_DEV: begin
                    if (dev_match) begin
                      do_ack   <= 1'b1;
                      is_rd    <= incoming[0];
                      rd_req_o <= incoming[0];
                    end else begin
                      st <= ST_IDLE;
                    end
                  end
                  ST_AHI: begin
                    addr_hi_stb_o <= 1'b1;
                    byte_o        <= incoming;
                    do_ack        <= 1'b1;
                  end
                  ST_ALO: begin
                    addr_lo_stb_o <= 1'b1;
                    byte_o        <= incoming;
                    do_ack        <= 1'b1;
                  end
                  default: begin
                    wr_stb_o <= 1'b1;
                    byte_o   <= incoming;
                    do_ack   <= 1'b1;
                    wrote    <= 1'b1;
                  end
                endcase
              end
            end else if (scl_fall && do_ack && !ack_slot) begin
              sda_drive_o <= 1'b1;
              ack_slot    <= 1'b1;
            end else if (scl_fall && ack_slot) begin
              ack_slot    <= 1'b0;
              do_ack      <= 1'b0;
              cnt         <= '0;
              sda_drive_o <= 1'b0;
              case (st)
                ST_DEV: begin
                  if (is_rd) begin
                    st          <= ST_READ;
                    shreg       <= rd_byte_i;
                    sda_drive_o <= ~rd_byte_i[BYTE_W-1];
                  end else begin
                    st <= ST_AHI;
                  end
                end
                ST_AHI:  st <= ST_ALO;
                ST_ALO:  st <= ST_WDATA;
                default: st <= ST_WDATA;
              endcase
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/twm_slave.sv
module twm_slave #(
  parameter int BYTE_W     = 8,
  parameter int STRAP_W    = 3,
  parameter int SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  input  logic [BYTE_W-1:0]  rd_byte_i,
  output logic               sda_drive_o,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               addr_hi_stb_o,
  output logic               addr_lo_stb_o,
  output logic               wr_stb_o,
  output logic               rd_req_o,
  output logic               commit_o
);
  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_ev, stop_ev;

  twm_sync #(.W(2), .STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({scl_i, sda_i}),
    .q_o (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  twm_line_events u_events (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  twm_xfer #(.BYTE_W(BYTE_W), .STRAP_W(STRAP_W)) u_xfer (
    .clk           (clk),
    .rst           (rst),
    .sda_s         (sda_s),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_ev      (start_ev),
    .stop_ev       (stop_ev),
    .strap_i       (strap_i),
    .busy_i        (busy_i),
    .rd_byte_i     (rd_byte_i),
    .sda_drive_o   (sda_drive_o),
    .byte_o        (byte_o),
    .addr_hi_stb_o (addr_hi_stb_o),
    .addr_lo_stb_o (addr_lo_stb_o),
    .wr_stb_o      (wr_stb_o),
    .rd_req_o      (rd_req_o),
    .commit_o      (commit_o)
  );
endmodule

// File: rtl/twm_slave_chk.sv
module twm_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic scl_rise,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_drive_o,
  input logic addr_hi_stb_o,
  input logic addr_lo_stb_o,
  input logic wr_stb_o,
  input logic rd_req_o,
  input logic commit_o
);
  logic [4:0] stbs;
  assign stbs = {addr_hi_stb_o, addr_lo_stb_o, wr_stb_o, rd_req_o, commit_o};

  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> (!sda_drive_o && stbs == 5'd0));

  p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_drive_o) |-> !scl_s);

  p_start_release_r1: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> !sda_drive_o);

  p_commit_on_stop_r6: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(stop_ev));

  p_one_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stbs));

  p_wr_after_rise_r5: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> $past(scl_rise));
endmodule

bind twm_slave twm_slave_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .scl_s         (scl_s),
  .scl_rise      (scl_rise),
  .start_ev      (start_ev),
  .stop_ev       (stop_ev),
  .sda_drive_o   (sda_drive_o),
  .addr_hi_stb_o (addr_hi_stb_o),
  .addr_lo_stb_o (addr_lo_stb_o),
  .wr_stb_o      (wr_stb_o),
  .rd_req_o      (rd_req_o),
  .commit_o      (commit_o)
);

// File: tb/twm_slave_tb_top.sv
`timescale 1ns/1ps
module twm_slave_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic busy = 1'b0;
  logic [2:0] strap = 3'b101;
  logic [7:0] rd_byte;
  logic sda_drive, addr_hi_stb, addr_lo_stb, wr_stb, rd_req, commit;
  logic [7:0] byte_o;
  logic sda_bus;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_drive;

  twm_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(strap),
    .busy_i(busy), .rd_byte_i(rd_byte), .sda_drive_o(sda_drive),
    .byte_o(byte_o), .addr_hi_stb_o(addr_hi_stb), .addr_lo_stb_o(addr_lo_stb),
    .wr_stb_o(wr_stb), .rd_req_o(rd_req), .commit_o(commit)
  );

  int checks = 0, fails = 0;
  int n_hi = 0, n_lo = 0, n_wr = 0, n_rd = 0, n_commit = 0;
  int multi_viol = 0, drive_viol = 0, scl_hi_cnt = 0;
  logic [7:0] last_hi, last_lo;
  logic [15:0] ca;
  logic [7:0] mem [int];
  logic prev_drive = 1'b0;
  bit done = 1'b0;
  int cyc = 0;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return 8'(a * 7 + 3);
  endfunction

  // behavioural companion block: address counter, page-wrapping writes, reads
  always @(posedge clk) begin
    if (rst) begin
      ca <= '0; rd_byte <= '0;
    end else begin
      if (addr_hi_stb) begin ca[15:8] <= byte_o; last_hi <= byte_o; n_hi++; end
      if (addr_lo_stb) begin ca[7:0] <= byte_o; last_lo <= byte_o; n_lo++; end
      if (wr_stb) begin mem[int'(ca)] = byte_o; ca <= {ca[15:7], ca[6:0] + 7'd1}; n_wr++; end
      if (rd_req) begin
        rd_byte <= mem.exists(int'(ca)) ? mem[int'(ca)] : pat(ca);
        ca <= ca + 16'd1; n_rd++;
      end
      if (commit) n_commit++;
      if ((32'(addr_hi_stb) + 32'(addr_lo_stb) + 32'(wr_stb) + 32'(rd_req) + 32'(commit)) > 1) multi_viol++;
      // drive may only move once SCL has been low; check against a long high phase
      scl_hi_cnt <= scl_m ? scl_hi_cnt + 1 : 0;
      if (sda_drive != prev_drive && scl_m && scl_hi_cnt > 4) drive_viol++;
      prev_drive <= sda_drive;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; hold(Q);
    scl_m = 1'b1; hold(Q/2);
    s = sda_bus; hold(Q/2);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit m_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); d[i] = s; end
    clk_bit(!m_ack, s);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    logic s;
    int c0, w0, h0;
    hold(5);
    check(sda_drive == 1'b0 && !wr_stb && !rd_req && !commit, "R11 reset", int'(sda_drive), 0);
    rst = 1'b0;
    hold(5);
    check(sda_drive == 1'b0, "R11 after reset", int'(sda_drive), 0);

    // write three bytes at 0x1234
    do_start();
    send_byte(8'hAA, ack); check(ack, "R2 matching write address ack", int'(ack), 1);
    send_byte(8'h12, ack); check(ack, "R3 high address ack", int'(ack), 1);
    send_byte(8'h34, ack); check(ack, "R3 low address ack", int'(ack), 1);
    send_byte(8'h5A, ack); check(ack, "R3 data ack", int'(ack), 1);
    send_byte(8'hC3, ack);
    send_byte(8'h0F, ack); check(ack, "R3 last data ack", int'(ack), 1);
    do_stop(); hold(4);
    check(n_hi == 1 && last_hi == 8'h12, "R5 high address strobe", int'(last_hi), 'h12);
    check(n_lo == 1 && last_lo == 8'h34, "R5 low address strobe", int'(last_lo), 'h34);
    check(n_wr == 3, "R5 write strobes", n_wr, 3);
    check(n_commit == 1, "R6 commit on stop", n_commit, 1);

    // random read from 0x1234
    do_start();
    send_byte(8'hAA, ack); send_byte(8'h12, ack); send_byte(8'h34, ack);
    do_start();
    send_byte(8'hAB, ack); check(ack, "R2 read address ack", int'(ack), 1);
    recv_byte(1'b1, d); check(d == 8'h5A, "R7 read byte 0", int'(d), 'h5A);
    recv_byte(1'b1, d); check(d == 8'hC3, "R7 read byte 1", int'(d), 'hC3);
    recv_byte(1'b0, d); check(d == 8'h0F, "R7 read byte 2", int'(d), 'h0F);
    clk_bit(1'b1, s); check(s == 1'b1, "R8 released after nack", int'(s), 1);
    do_stop(); hold(4);
    check(n_commit == 1, "R6 no commit for address-only write", n_commit, 1);
    check(n_rd == 3, "R7 fetch count", n_rd, 3);

    // current-address read continues at 0x1237
    do_start();
    send_byte(8'hAB, ack);
    recv_byte(1'b0, d); check(d == pat(16'h1237), "R7 current address read", int'(d), int'(pat(16'h1237)));
    do_stop();

    // wrong strap and wrong type
    w0 = n_wr; h0 = n_hi;
    do_start();
    send_byte(8'hA2, ack); check(!ack, "R2 strap mismatch nack", int'(ack), 0);
    send_byte(8'h00, ack); check(!ack, "R2 ignored after mismatch", int'(ack), 0);
    do_stop();
    do_start();
    send_byte(8'hBA, ack); check(!ack, "R2 type mismatch nack", int'(ack), 0);
    do_stop(); hold(4);
    check(n_wr == w0 && n_hi == h0, "R2 no strobes after mismatch", n_wr - w0, 0);

    // busy around the eighth address bit
    do_start();
    begin
      for (int i = 7; i >= 1; i--) clk_bit(8'hAA >> i, s);
      busy = 1'b1;
      clk_bit(1'b0, s);
      hold(3); busy = 1'b0;
      clk_bit(1'b1, s);
      check(s == 1'b1, "R9 busy nack", int'(!s), 0);
    end
    do_stop();
    do_start();
    send_byte(8'hAA, ack); check(ack, "R9 ack once not busy", int'(ack), 1);
    do_stop();

    // repeated START right after a data byte: strobe yes, commit no
    c0 = n_commit; w0 = n_wr;
    do_start();
    send_byte(8'hAA, ack); send_byte(8'h00, ack); send_byte(8'h10, ack);
    send_byte(8'h77, ack);
    do_start(); do_stop(); hold(4);
    check(n_wr == w0 + 1, "R5 strobe before abort", n_wr - w0, 1);
    check(n_commit == c0, "R6 no commit after START abort", n_commit - c0, 0);

    // recovery sequence from inside an address byte
    do_start();
    send_byte(8'hAA, ack);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    h0 = n_hi;
    do_start();
    for (int i = 0; i < 9; i++) clk_bit(1'b1, s);
    do_start(); do_stop(); hold(4);
    check(sda_drive == 1'b0 && n_hi == h0, "R10 idle after recovery", int'(sda_drive), 0);
    do_start();
    send_byte(8'hAA, ack); send_byte(8'h12, ack); send_byte(8'h35, ack);
    do_start();
    send_byte(8'hAB, ack); check(ack, "R1 ack after recovery", int'(ack), 1);
    recv_byte(1'b0, d); check(d == 8'hC3, "R10 read after recovery", int'(d), 'hC3);
    do_stop(); hold(4);

    check(multi_viol == 0, "R12 single strobe", multi_viol, 0);
    check(drive_viol == 0, "R4 drive only with SCL low", drive_viol, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule